// File: doc/BRIEF.md
# Wide-to-Narrow Write Burst Downsizer

This block accepts a write burst from a 64-bit upstream bus and replays it as a series of 16-bit external memory cycles. Each 64-bit beat is cut into two 32-bit intermediate words, lower half first. Each word is then cut into two halfwords, low halfword first. Every 64-bit beat therefore becomes exactly four external cycles.

The number of external cycles comes from the burst's byte count and not from its byte enables. A halfword whose lanes are all masked still occupies a full external cycle. In that cycle the write strobe and both byte strobes stay inactive and the data is zero. The external address is the request address relative to a chip-select window base, and it advances by two bytes per cycle.

The request header (address and byte count) is sampled with the first beat of a burst. While a beat is being serialized the upstream ready is held low. Requests that are misaligned, have a bad byte count or fall outside the window are rejected with an error pulse.

Top module: `wburst_downsizer`

## Requirements
- R1: After reset, `ext_cyc` is 0, `up_ready` is 1, `burst_done` and `burst_err` are 0, `ext_we_n` is 1, `ext_be_n` is 2'b11 and `ext_data` is 0.
- R2: Each accepted 64-bit beat yields exactly four consecutive cycles with `ext_cyc` high, starting in the cycle after the beat is accepted. A burst of N bytes therefore yields N/2 external cycles whatever its enables are.
- R3: Beat byte pairs are issued in the order bytes 1:0, 3:2, 5:4, 7:6. The lower 32-bit half goes before the upper half, and the low halfword of each half goes first.
- R4: `ext_addr` for the k-th cycle of a burst (k from 0) equals (request address minus `WIN_BASE`) + 2k, modulo 2^`WIN_W`. Address and byte count presented with later beats of the same burst are ignored.
- R5: `ext_be_n[i]` is the inverse of the upstream enable of the byte driven on lane i (lane 0 = bits 7:0). `ext_we_n` is 0 exactly when at least one lane of the cycle is enabled.
- R6: Each `ext_data` byte equals the matching upstream byte when its lane is enabled and is 0 when masked.
- R7: `up_ready` is low during the four cycles of a beat and high in every other cycle. The next beat is accepted no earlier than the cycle after the fourth cycle.
- R8: A first beat whose byte count is 0 or not a multiple of 8, whose address is not 8-byte aligned, or whose address lies outside the window (upper `ADDR_W-WIN_W` bits not equal to those of `WIN_BASE`) is consumed without any external cycle. `burst_err` is high for exactly the one cycle after it is accepted.
- R9: `burst_done` is high for exactly one cycle: the cycle after the last external cycle of a burst.
- R10: Whenever `ext_cyc` is low, `ext_be_n` is 2'b11, `ext_we_n` is 1 and `ext_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream beat valid |
| up_ready | output | 1 | Upstream beat ready |
| up_addr | input | ADDR_W (32) | Burst start address, sampled with the first beat |
| up_bytecnt | input | CNT_W (12) | Burst byte count, sampled with the first beat |
| up_data | input | UP_W (64) | Beat data |
| up_be | input | UP_W/8 (8) | Beat byte enables, active high |
| ext_cyc | output | 1 | External cycle in progress |
| ext_addr | output | WIN_W (23) | External byte address within the window |
| ext_be_n | output | EXT_W/8 (2) | External byte enables, active low |
| ext_we_n | output | 1 | External write enable, active low |
| ext_data | output | EXT_W (16) | External write data |
| burst_done | output | 1 | One-cycle pulse after the last external cycle |
| burst_err | output | 1 | One-cycle pulse after a rejected request |

## Verification
An accepted beat shows its first external cycle in the next cycle and its fourth cycle three cycles after that. The done pulse follows the final cycle by one cycle, and the error pulse follows a rejected acceptance by one cycle. The bench reference model sees the handshake at the falling edge that precedes the capturing rising edge. It pushes the four expected cycles into a queue and pops one entry at each later falling edge, so every comparison falls in exactly the cycle where the registered outputs are due. Idle cycles, ready, done and error are compared on every falling edge as well.

// File: rtl/wbd_pkg.sv
package wbd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2
   } wbd_state_e;
endpackage

// File: rtl/wbd_narrow.sv
module wbd_narrow #(
   parameter int IN_W  = 64,
   parameter int OUT_W = 32,
   localparam int RATIO = IN_W / OUT_W,
   localparam int SEL_W = $clog2(RATIO),
   localparam int IB    = IN_W / 8,
   localparam int OB    = OUT_W / 8
) (
   input  logic [IN_W-1:0]  din,
   input  logic [IB-1:0]    bein,
   input  logic [SEL_W-1:0] sel,
   output logic [OUT_W-1:0] dout,
   output logic [OB-1:0]    beout
);
   if (IN_W % OUT_W != 0 || RATIO < 2 || (1 << SEL_W) != RATIO) begin : g_bad_ratio
      $error("wbd_narrow: IN_W must be a power-of-two multiple of OUT_W");
   end
   if (OUT_W % 8 != 0) begin : g_bad_bytes
      $error("wbd_narrow: OUT_W must be whole bytes");
   end

   for (genvar b = 0; b < OB; b++) begin : g_lane
      logic [7:0] src_byte;
      logic       src_en;
      always_comb begin
         src_en   = bein[int'(sel) * OB + b];
         src_byte = din[(int'(sel) * OB + b) * 8 +: 8];
      end
      assign beout[b]          = src_en;
      assign dout[b*8 +: 8]    = src_en ? src_byte : 8'h00;
   end
endmodule

// File: rtl/wbd_seq.sv
module wbd_seq
   import wbd_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          CNT_W      = 12,
   parameter int          WIN_W      = 23,
   parameter logic [31:0] WIN_BASE   = 32'h1000_0000,
   parameter int          BEAT_BYTES = 8,
   parameter int          EXT_BYTES  = 2,
   parameter int          SLOT_W     = 2,
   localparam int         AL_W       = $clog2(BEAT_BYTES),
   localparam int         SLOTS      = 1 << SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [CNT_W-1:0]  up_bytecnt,
   output logic              load,
   output logic [SLOT_W-1:0] slot,
   output logic              ext_cyc,
   output logic [WIN_W-1:0]  ext_addr,
   output logic              done,
   output logic              err
);
   if (WIN_W >= ADDR_W || WIN_W <= AL_W) begin : g_bad_win
      $error("wbd_seq: WIN_W must lie between the beat alignment and ADDR_W");
   end
   if (SLOTS * EXT_BYTES != BEAT_BYTES) begin : g_bad_slots
      $error("wbd_seq: slot count does not cover one beat");
   end

   wbd_state_e       state_q;
   logic [SLOT_W-1:0] slot_q;
   logic [CNT_W-1:0]  beats_q;
   logic [WIN_W-1:0]  off_q;
   logic              hs, aligned, in_win, req_ok, last_slot;
   logic [ADDR_W-1:0] base_vec;

   assign base_vec  = ADDR_W'(WIN_BASE);
   assign hs        = up_valid && up_ready;
   assign in_win    = (up_addr[ADDR_W-1:WIN_W] == base_vec[ADDR_W-1:WIN_W]);
   assign aligned   = (up_addr[AL_W-1:0] == '0) && (up_bytecnt[AL_W-1:0] == '0);
   assign req_ok    = aligned && in_win && (up_bytecnt != '0);
   assign last_slot = (slot_q == SLOT_W'(SLOTS - 1));
   assign load      = hs && ((state_q == ST_WAIT) || (state_q == ST_IDLE && req_ok));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         slot_q  <= '0;
         beats_q <= '0;
         off_q   <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (hs) begin
                  if (req_ok) begin
                     off_q   <= up_addr[WIN_W-1:0] - base_vec[WIN_W-1:0];
                     beats_q <= up_bytecnt >> AL_W;
                     slot_q  <= '0;
                     state_q <= ST_SEND;
                  end else begin
                     err <= 1'b1;
                  end
               end
            end
            ST_SEND: begin
               off_q <= off_q + WIN_W'(EXT_BYTES);
               if (last_slot) begin
                  slot_q  <= '0;
                  beats_q <= beats_q - CNT_W'(1);
                  if (beats_q == CNT_W'(1)) begin
                     state_q <= ST_IDLE;
                     done    <= 1'b1;
                  end else begin
                     state_q <= ST_WAIT;
                  end
               end else begin
                  slot_q <= slot_q + SLOT_W'(1);
               end
            end
            ST_WAIT: begin
               if (hs) state_q <= ST_SEND;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign slot     = slot_q;
   assign ext_cyc  = (state_q == ST_SEND);
   assign ext_addr = off_q;
   assign up_ready = (state_q != ST_SEND);

   // R2
   beat_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_cyc && !last_slot) |=> ext_cyc);
   // R9
   done_after_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(ext_cyc) && !ext_cyc));
   // R8
   err_no_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!ext_cyc && $past(up_valid)));
endmodule

// File: rtl/wburst_downsizer.sv
module wburst_downsizer #(
   parameter int          ADDR_W   = 32,
   parameter int          CNT_W    = 12,
   parameter int          WIN_W    = 23,
   parameter logic [31:0] WIN_BASE = 32'h1000_0000,
   parameter int          UP_W     = 64,
   parameter int          MID_W    = 32,
   parameter int          EXT_W    = 16,
   localparam int         UP_B     = UP_W / 8,
   localparam int         EXT_B    = EXT_W / 8,
   localparam int         SEL1_W   = $clog2(UP_W / MID_W),
   localparam int         SEL2_W   = $clog2(MID_W / EXT_W),
   localparam int         SLOT_W   = SEL1_W + SEL2_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [CNT_W-1:0]  up_bytecnt,
   input  logic [UP_W-1:0]   up_data,
   input  logic [UP_B-1:0]   up_be,
   output logic              ext_cyc,
   output logic [WIN_W-1:0]  ext_addr,
   output logic [EXT_B-1:0]  ext_be_n,
   output logic              ext_we_n,
   output logic [EXT_W-1:0]  ext_data,
   output logic              burst_done,
   output logic              burst_err
);
   if (ADDR_W > 32) begin : g_bad_addr
      $error("wburst_downsizer: ADDR_W limited to 32 by WIN_BASE");
   end
   if (EXT_W % 8 != 0 || MID_W % EXT_W != 0 || UP_W % MID_W != 0) begin : g_bad_w
      $error("wburst_downsizer: widths must nest in whole bytes");
   end

   logic              load;
   logic [SLOT_W-1:0] slot;
   logic [UP_W-1:0]   beat_d;
   logic [UP_B-1:0]   beat_be;
   logic [MID_W-1:0]  mid_d;
   logic [MID_W/8-1:0] mid_be;
   logic [EXT_W-1:0]  half_d;
   logic [EXT_B-1:0]  half_be;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_d  <= '0;
         beat_be <= '0;
      end else if (load) begin
         beat_d  <= up_data;
         beat_be <= up_be;
      end
   end

   wbd_seq #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIN_W(WIN_W), .WIN_BASE(WIN_BASE),
      .BEAT_BYTES(UP_B), .EXT_BYTES(EXT_B), .SLOT_W(SLOT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
      .up_addr(up_addr), .up_bytecnt(up_bytecnt), .load(load), .slot(slot),
      .ext_cyc(ext_cyc), .ext_addr(ext_addr), .done(burst_done), .err(burst_err)
   );

   // upper slot bits pick the intermediate half, lower bits the halfword
   wbd_narrow #(.IN_W(UP_W), .OUT_W(MID_W)) u_to_mid (
      .din(beat_d), .bein(beat_be), .sel(slot[SLOT_W-1:SEL2_W]),
      .dout(mid_d), .beout(mid_be)
   );
   wbd_narrow #(.IN_W(MID_W), .OUT_W(EXT_W)) u_to_ext (
      .din(mid_d), .bein(mid_be), .sel(slot[SEL2_W-1:0]),
      .dout(half_d), .beout(half_be)
   );

   assign ext_be_n = ext_cyc ? ~half_be : '1;
   assign ext_we_n = !(ext_cyc && (|half_be));
   assign ext_data = ext_cyc ? half_d : '0;

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_cyc |-> (ext_be_n == '1 && ext_we_n && ext_data == '0));
   // R4
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_cyc && $past(ext_cyc)) |-> (ext_addr == $past(ext_addr) + WIN_W'(EXT_B)));
   // R6
   masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_we_n |-> (ext_data == '0));
   // R7
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(up_valid && up_ready) && ext_cyc) |-> !up_ready);
endmodule

// File: tb/sim_wburst_downsizer.sv
module sim_wburst_downsizer;
   localparam int          WIN_W    = 23;
   localparam logic [31:0] WIN_BASE = 32'h1000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_valid = 1'b0;
   logic        up_ready;
   logic [31:0] up_addr = '0;
   logic [11:0] up_bytecnt = '0;
   logic [63:0] up_data = '0;
   logic [7:0]  up_be = '0;
   logic        ext_cyc;
   logic [22:0] ext_addr;
   logic [1:0]  ext_be_n;
   logic        ext_we_n;
   logic [15:0] ext_data;
   logic        burst_done, burst_err;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   wburst_downsizer u0 (
      .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
      .up_addr(up_addr), .up_bytecnt(up_bytecnt), .up_data(up_data), .up_be(up_be),
      .ext_cyc(ext_cyc), .ext_addr(ext_addr), .ext_be_n(ext_be_n), .ext_we_n(ext_we_n),
      .ext_data(ext_data), .burst_done(burst_done), .burst_err(burst_err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // reference model
   typedef struct {
      int addr;
      int ben;
      int wen;
      int data;
      bit last;
   } cyc_t;
   cyc_t exp_q[$];
   bit   m_in = 0;
   int   m_left = 0;
   int   m_off = 0;
   bit   exp_done = 0;
   bit   exp_err = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         bit nd, ne;
         nd = 0;
         ne = 0;
         if (exp_q.size() > 0) begin
            cyc_t c;
            c = exp_q.pop_front();
            chk(ext_cyc == 1'b1, "R2 cycle present", int'(ext_cyc), 1);
            chk(int'(ext_addr) == c.addr, "R4 address", int'(ext_addr), c.addr);
            chk(int'(ext_be_n) == c.ben, "R5 byte enables", int'(ext_be_n), c.ben);
            chk(int'(ext_we_n) == c.wen, "R5 write enable", int'(ext_we_n), c.wen);
            chk(int'(ext_data) == c.data, "R3 R6 data", int'(ext_data), c.data);
            chk(up_ready == 1'b0, "R7 ready low", int'(up_ready), 0);
            nd = c.last;
         end else begin
            chk(ext_cyc == 1'b0, "R2 no extra cycle", int'(ext_cyc), 0);
            chk(ext_be_n == 2'b11 && ext_we_n && ext_data == 16'h0, "R10 idle pins",
                int'({ext_be_n, ext_we_n, ext_data}), int'({2'b11, 1'b1, 16'h0}));
            chk(up_ready == 1'b1, "R7 ready high", int'(up_ready), 1);
         end
         chk(burst_done == exp_done, "R9 done pulse", int'(burst_done), int'(exp_done));
         chk(burst_err == exp_err, "R8 error pulse", int'(burst_err), int'(exp_err));
         if (up_valid && up_ready) begin
            if (!m_in) begin
               if (up_addr % 8 != 0 || up_bytecnt % 8 != 0 || up_bytecnt == 0 ||
                   (up_addr >> WIN_W) != (WIN_BASE >> WIN_W)) begin
                  ne = 1;
               end else begin
                  m_in   = 1;
                  m_left = int'(up_bytecnt) / 8;
                  m_off  = int'(up_addr - WIN_BASE) & ((1 << WIN_W) - 1);
               end
            end
            if (m_in) begin
               for (int k = 0; k < 4; k++) begin
                  cyc_t e;
                  bit   e0, e1;
                  e0 = up_be[2*k];
                  e1 = up_be[2*k+1];
                  e.addr = m_off;
                  e.ben  = {~e1, ~e0};
                  e.wen  = !(e0 || e1);
                  e.data = {e1 ? up_data[16*k+8 +: 8] : 8'h00, e0 ? up_data[16*k +: 8] : 8'h00};
                  e.last = (k == 3 && m_left == 1);
                  exp_q.push_back(e);
                  m_off = (m_off + 2) & ((1 << WIN_W) - 1);
               end
               m_left--;
               if (m_left == 0) m_in = 0;
            end
         end
         exp_done = nd;
         exp_err  = ne;
      end
   end

   task automatic send_beat(input logic [31:0] a, input logic [11:0] n,
                            input logic [63:0] d, input logic [7:0] be);
      bit hs;
      up_valid   = 1'b1;
      up_addr    = a;
      up_bytecnt = n;
      up_data    = d;
      up_be      = be;
      do begin
         @(negedge clk);
         hs = up_ready;
         @(posedge clk);
         #1;
      end while (!hs);
      up_valid = 1'b0;
      up_data  = $urandom;
      up_be    = 8'($urandom);
   endtask

   // mode: 0 all enabled, 1 none, 2 random, 3 alternating lanes
   task automatic send_burst(input logic [31:0] a, input int n, input int mode, input int gap);
      for (int i = 0; i < (n > 0 ? (n + 7) / 8 : 1); i++) begin
         logic [7:0] be;
         case (mode)
            0: be = 8'hFF;
            1: be = 8'h00;
            3: be = (i % 2 == 0) ? 8'h5A : 8'hA5;
            default: be = 8'($urandom);
         endcase
         // later beats carry unrelated header values (R4: ignored)
         send_beat(i == 0 ? a : a + 32'h40, i == 0 ? 12'(n) : 12'h008,
                   {$urandom, $urandom}, be);
         repeat (gap) @(posedge clk);
         #1;
         if (i == 0 && (a % 8 != 0 || n % 8 != 0 || n == 0 ||
                        (a >> WIN_W) != (WIN_BASE >> WIN_W))) break;
      end
      repeat (6) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset values
      chk(ext_cyc == 1'b0, "R1 ext_cyc", int'(ext_cyc), 0);
      chk(up_ready == 1'b1, "R1 up_ready", int'(up_ready), 1);
      chk(!burst_done && !burst_err, "R1 pulses", int'({burst_done, burst_err}), 0);
      chk(ext_we_n == 1'b1 && ext_be_n == 2'b11 && ext_data == 16'h0, "R1 strobes",
          int'({ext_be_n, ext_we_n, ext_data}), int'({2'b11, 1'b1, 16'h0}));
      @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      // worked example: upper half then lower half enabled
      send_beat(32'h1000_0000, 12'd16, 64'h0000_0001_0000_0000, 8'hF0);
      send_beat(32'h1000_0000, 12'd16, 64'h0000_0000_0000_0002, 8'h0F);
      repeat (8) @(posedge clk);
      #1;
      send_burst(32'h1000_0100, 32, 0, 0);   // R2 R3 full enables
      send_burst(32'h1000_0200, 24, 1, 2);   // R5 all phantom
      send_burst(32'h1000_0308, 64, 2, 1);   // R6 random enables
      send_burst(32'h1000_0400, 16, 3, 3);   // R5 partial halfwords
      send_burst(32'h1000_0500, 8, 2, 0);    // R9 single beat
      send_burst(32'h107F_FFF8, 16, 0, 0);   // R4 window wrap
      send_burst(32'h1000_0604, 16, 0, 0);   // R8 misaligned address
      send_burst(32'h1000_0700, 12, 0, 0);   // R8 bad count
      send_burst(32'h1000_0800, 0, 0, 0);    // R8 zero count
      send_burst(32'h2000_0000, 16, 0, 0);   // R8 outside window
      for (int t = 0; t < 20; t++) begin
         send_burst(WIN_BASE + (32'($urandom_range(0, 4000)) << 3),
                    8 * $urandom_range(1, 8), $urandom_range(0, 3), $urandom_range(0, 2));
      end
      repeat (10) @(posedge clk);
      #1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog R2 actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule